// File: doc/BRIEF.md
# Moving-Head Disk Command Sequencer

This block is the command and status engine of a controller that serves up to eight moving-head disk drives. Software reaches it through a small register port: a control/status word (function code, GO strobe, unit number, interrupt enable, completion flag and error flags), a sector/track address register, a cylinder address register, a per-unit drive status word and a write-lock boundary register. Writing the control/status word with GO set issues one of five functions (reset, write, read, seek, home) to the selected unit. The block raises a level interrupt request while completion and interrupt enable are both set.

Reads and writes go to an abstract sector-transfer engine. The block pulses a start strobe, then waits for the engine's done strobe, which carries an error flag with it. Once a transfer has started, the disk address always moves on by one sector at completion, carrying into the track and the cylinder, even when the engine reports a fault. Seek and home do not complete at once. Completion follows a fixed countdown of `DONE_DLY` cycles, so that software can clear its interrupt flag after issuing the command and still see the interrupt. Each unit keeps its own status: positioning, seek-incomplete and write-lock violation. Each drive reports the outcome of a seek on its own seek-complete and seek-fail inputs.

The sequencer has four states. IDLE accepts commands. WAIT runs the completion countdown for seek, home and rejected commands. XSTART drives the transfer start strobe for one cycle. XWAIT waits for the engine. The transitions are:
- IDLE→XSTART on an accepted read or write.
- IDLE→WAIT on seek, home or a rejected command.
- WAIT→IDLE when the countdown expires.
- XSTART→XWAIT unconditionally.
- XWAIT→IDLE on the engine's done.
- Any state→IDLE on a reset function.

Top module: `dsk_cmd_seq`

## Requirements
- R1: After reset, the control/status word (address 0) reads 0x0080 (DONE, bit 7, set; everything else clear). The disk address (address 1), the cylinder (address 2) and the lock boundary (address 4) read 0. Every unit's status (address 3) reads 0x0001 (bit 0 = ready). irq is low.
- R2: irq is high exactly when DONE (bit 7) and interrupt enable (bit 8) are both set. It rises in the cycle after DONE is set while enable is set, or after enable is written to 1 while DONE is set.
- R3: A GO write with function code 0 (reset) is accepted in any state. In the next cycle DONE is set, the enable takes the written bit 8, the function/unit fields take the written values, and error bits 15..11 and every unit's write-lock flag are cleared. A transfer that was in progress is abandoned, and its later done strobe leaves the address registers unchanged.
- R4: A seek (code 3) or home (code 4) clears DONE at the GO edge. DONE is set again exactly `DONE_DLY` cycles after that edge.
- R5: A read (code 2) or write (code 1) to a ready, unlocked unit pulses xfer_start in the cycle after GO, with xfer_write high for a write. DONE stays clear until the cycle after xfer_done.
- R6: At the end of a started transfer, the sector (address 1, bits 3:0) advances by one. It wraps at `SECT_PER_TRK` into the track (bits 12:8), which wraps at `TRK_PER_CYL` into the cylinder. This happens whether or not xfer_err is high, and xfer_err sets bit 14.
- R7: Advancing past the last sector of the last track of cylinder `NUM_CYL`-1 sets all three address fields to 0 and sets the overflow bit 13.
- R8: Home is executed on a unit that is not ready. It clears that unit's seek-incomplete condition, so the unit reads ready in the cycle after GO.
- R9: A seek sets the unit's positioning bit (status bit 1, not ready) until the unit's seek_cmpl pulse. A seek_fail pulse instead sets seek-incomplete (status bit 2). That condition survives further commands and the reset function, and only home clears it.
- R10: A read, write or seek to a unit that is not ready starts nothing. It sets the not-ready bit 12 and sets DONE `DONE_DLY` cycles after GO.
- R11: A write to a cylinder below the lock boundary starts no transfer and leaves the address registers unchanged. It sets write-lock bit 11 and the unit's status bit 3, and sets DONE `DONE_DLY` cycles after GO. A read of the same cylinder proceeds normally.
- R12: The status word shows the unit held in the control/status unit field (bits 6:4). A condition on one unit does not appear on any other unit.
- R13: A GO write with codes 5 to 7 while idle, or with any non-reset code while busy, starts nothing. DONE keeps its value, and a busy command keeps its function and unit. Bit 15 always reads as the OR of bits 14..11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select: 0 control/status, 1 sector/track, 2 cylinder, 3 unit status, 4 lock boundary |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr (combinational) |
| irq | output | 1 | Level interrupt request |
| xfer_start | output | 1 | One-cycle transfer start strobe |
| xfer_write | output | 1 | Transfer direction, 1 = write |
| xfer_unit | output | UNIT_W | Unit of the transfer |
| xfer_done | input | 1 | Transfer engine completion strobe |
| xfer_err | input | 1 | Transfer fault, valid with xfer_done |
| seek_cmpl | input | NUM_DRV | Per-unit seek completed strobe |
| seek_fail | input | NUM_DRV | Per-unit seek failed strobe |

## Verification
A wrong sequencer state would show as a misplaced xfer_start edge, or as DONE and irq appearing a cycle early or late. The bench measures those edges against the GO write to the exact cycle. A wrong address-advance state would show in the sector/track and cylinder readback on the first completion after it. A lost or leaked per-unit condition would show in the unit status word and in the not-ready bit of the next command issued to that unit. Bench checks sample these right after the edge that should change them. Bound properties flag an early DONE, a missing interrupt or an address that did not move in the cycle it happens.

// File: rtl/dsk_pkg.sv
package dsk_pkg;

    localparam int REG_W = 16;

    // function codes in the control/status word, bits 3:1
    localparam logic [2:0] FN_RESET = 3'd0;
    localparam logic [2:0] FN_WRITE = 3'd1;
    localparam logic [2:0] FN_READ  = 3'd2;
    localparam logic [2:0] FN_SEEK  = 3'd3;
    localparam logic [2:0] FN_HOME  = 3'd4;

    // register addresses
    localparam logic [2:0] RA_CS   = 3'd0;
    localparam logic [2:0] RA_DA   = 3'd1;
    localparam logic [2:0] RA_CA   = 3'd2;
    localparam logic [2:0] RA_DS   = 3'd3;
    localparam logic [2:0] RA_LOCK = 3'd4;

    // control/status bit positions
    localparam int CS_GO   = 0;
    localparam int CS_FN   = 1;
    localparam int CS_UNIT = 4;
    localparam int CS_DONE = 7;
    localparam int CS_IE   = 8;
    localparam int CS_WL   = 11;
    localparam int CS_NRDY = 12;
    localparam int CS_OVF  = 13;
    localparam int CS_XFR  = 14;
    localparam int CS_ERR  = 15;

    // track field offset in the disk address register
    localparam int DA_TRK = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_XSTART,
        ST_XWAIT
    } seq_state_e;

    typedef struct packed {
        logic wlv;
        logic seek_inc;
        logic positioning;
    } drv_st_t;

endpackage

// File: rtl/dsk_done_timer.sv
module dsk_done_timer #(
    parameter int DONE_DLY = 16,
    localparam int DLY_W = $clog2(DONE_DLY + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic zero
);

    logic [DLY_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= DLY_W'(DONE_DLY - 1);
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/dsk_addr_step.sv
module dsk_addr_step #(
    parameter int SECT_PER_TRK = 12,
    parameter int TRK_PER_CYL  = 20,
    parameter int NUM_CYL      = 203,
    localparam int SECT_W = $clog2(SECT_PER_TRK),
    localparam int TRK_W  = $clog2(TRK_PER_CYL),
    localparam int CYL_W  = $clog2(NUM_CYL)
) (
    input  logic [SECT_W-1:0] sect,
    input  logic [TRK_W-1:0]  trk,
    input  logic [CYL_W-1:0]  cyl,
    output logic [SECT_W-1:0] nxt_sect,
    output logic [TRK_W-1:0]  nxt_trk,
    output logic [CYL_W-1:0]  nxt_cyl,
    output logic              ovf
);

    always_comb begin
        nxt_sect = sect + 1'b1;
        nxt_trk  = trk;
        nxt_cyl  = cyl;
        ovf      = 1'b0;
        if (sect >= SECT_W'(SECT_PER_TRK - 1)) begin
            nxt_sect = '0;
            if (trk >= TRK_W'(TRK_PER_CYL - 1)) begin
                nxt_trk = '0;
                if (cyl >= CYL_W'(NUM_CYL - 1)) begin
                    nxt_cyl = '0;
                    ovf     = 1'b1;
                end else begin
                    nxt_cyl = cyl + 1'b1;
                end
            end else begin
                nxt_trk = trk + 1'b1;
            end
        end
    end

endmodule

// File: rtl/dsk_drive_unit.sv
module dsk_drive_unit
    import dsk_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    home,
    input  logic    seek_go,
    input  logic    wl_hit,
    input  logic    clr_wl,
    input  logic    seek_cmpl,
    input  logic    seek_fail,
    output drv_st_t st,
    output logic    ready
);

    drv_st_t st_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            if (home) begin
                st_q.positioning <= 1'b0;
                st_q.seek_inc    <= 1'b0;
            end else if (seek_go) begin
                st_q.positioning <= 1'b1;
            end else if (st_q.positioning && seek_fail) begin
                st_q.positioning <= 1'b0;
                st_q.seek_inc    <= 1'b1;
            end else if (st_q.positioning && seek_cmpl) begin
                st_q.positioning <= 1'b0;
            end
            if (clr_wl) begin
                st_q.wlv <= 1'b0;
            end else if (wl_hit) begin
                st_q.wlv <= 1'b1;
            end
        end
    end

    assign st    = st_q;
    assign ready = !st_q.positioning && !st_q.seek_inc;

endmodule

// File: rtl/dsk_cmd_seq.sv
module dsk_cmd_seq
    import dsk_pkg::*;
#(
    parameter int NUM_DRV      = 8,
    parameter int SECT_PER_TRK = 12,
    parameter int TRK_PER_CYL  = 20,
    parameter int NUM_CYL      = 203,
    parameter int DONE_DLY     = 16,
    localparam int UNIT_W = $clog2(NUM_DRV),
    localparam int SECT_W = $clog2(SECT_PER_TRK),
    localparam int TRK_W  = $clog2(TRK_PER_CYL),
    localparam int CYL_W  = $clog2(NUM_CYL)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [2:0]         reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    output logic               irq,
    output logic               xfer_start,
    output logic               xfer_write,
    output logic [UNIT_W-1:0]  xfer_unit,
    input  logic               xfer_done,
    input  logic               xfer_err,
    input  logic [NUM_DRV-1:0] seek_cmpl,
    input  logic [NUM_DRV-1:0] seek_fail
);

    seq_state_e state_q, state_d;

    logic [2:0]        func_q;
    logic [UNIT_W-1:0] unit_q;
    logic              ie_q, done_q;
    logic              err_wl_q, err_nrdy_q, err_ovf_q, err_xfr_q;
    logic [SECT_W-1:0] sect_q, nxt_sect;
    logic [TRK_W-1:0]  trk_q, nxt_trk;
    logic [CYL_W-1:0]  cyl_q, nxt_cyl, lock_q;
    logic              step_ovf, tmr_zero;

    // register write decode
    logic              cs_wr, go, reset_go, start_go, busy, locked, unit_rdy, to_xfer;
    logic [2:0]        wfn;
    logic [UNIT_W-1:0] wunit;
    logic              unused_wbits;

    assign cs_wr    = reg_wr && reg_addr == RA_CS;
    assign go       = cs_wr && reg_wdata[CS_GO];
    assign wfn      = reg_wdata[CS_FN +: 3];
    assign wunit    = reg_wdata[CS_UNIT +: UNIT_W];
    assign busy     = state_q != ST_IDLE;
    assign reset_go = go && wfn == FN_RESET;
    assign start_go = go && !busy &&
                      (wfn inside {FN_WRITE, FN_READ, FN_SEEK, FN_HOME});
    assign locked   = cyl_q < lock_q;
    assign unused_wbits = ^reg_wdata;

    // per-unit status
    drv_st_t           drv_st [NUM_DRV];
    logic [NUM_DRV-1:0] drv_rdy;

    assign unit_rdy = drv_rdy[wunit];
    assign to_xfer  = (wfn == FN_READ || wfn == FN_WRITE) && unit_rdy &&
                      !(wfn == FN_WRITE && locked);

    for (genvar u = 0; u < NUM_DRV; u++) begin : g_drv
        logic sel;
        assign sel = start_go && wunit == UNIT_W'(u);
        dsk_drive_unit i_unit (
            .clk       (clk),
            .rst_n     (rst_n),
            .home      (sel && wfn == FN_HOME),
            .seek_go   (sel && wfn == FN_SEEK && unit_rdy),
            .wl_hit    (sel && wfn == FN_WRITE && unit_rdy && locked),
            .clr_wl    (reset_go),
            .seek_cmpl (seek_cmpl[u]),
            .seek_fail (seek_fail[u]),
            .st        (drv_st[u]),
            .ready     (drv_rdy[u])
        );
    end

    dsk_addr_step #(
        .SECT_PER_TRK (SECT_PER_TRK),
        .TRK_PER_CYL  (TRK_PER_CYL),
        .NUM_CYL      (NUM_CYL)
    ) i_step (
        .sect     (sect_q),
        .trk      (trk_q),
        .cyl      (cyl_q),
        .nxt_sect (nxt_sect),
        .nxt_trk  (nxt_trk),
        .nxt_cyl  (nxt_cyl),
        .ovf      (step_ovf)
    );

    dsk_done_timer #(.DONE_DLY(DONE_DLY)) i_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (state_q == ST_IDLE && state_d == ST_WAIT),
        .run   (state_q == ST_WAIT),
        .zero  (tmr_zero)
    );

    // next state
    always_comb begin
        state_d = state_q;
        if (reset_go) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   if (start_go) state_d = to_xfer ? ST_XSTART : ST_WAIT;
                ST_WAIT:   if (tmr_zero) state_d = ST_IDLE;
                ST_XSTART: state_d = ST_XWAIT;
                ST_XWAIT:  if (xfer_done) state_d = ST_IDLE;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // command, status and address registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            func_q     <= FN_RESET;
            unit_q     <= '0;
            ie_q       <= 1'b0;
            done_q     <= 1'b1;
            err_wl_q   <= 1'b0;
            err_nrdy_q <= 1'b0;
            err_ovf_q  <= 1'b0;
            err_xfr_q  <= 1'b0;
            sect_q     <= '0;
            trk_q      <= '0;
            cyl_q      <= '0;
            lock_q     <= '0;
        end else begin
            if (cs_wr) ie_q <= reg_wdata[CS_IE];
            if (reset_go) begin
                func_q     <= FN_RESET;
                unit_q     <= wunit;
                done_q     <= 1'b1;
                err_wl_q   <= 1'b0;
                err_nrdy_q <= 1'b0;
                err_ovf_q  <= 1'b0;
                err_xfr_q  <= 1'b0;
            end else begin
                if (cs_wr && !busy) begin
                    func_q <= wfn;
                    unit_q <= wunit;
                end
                if (start_go) begin
                    done_q     <= 1'b0;
                    err_ovf_q  <= 1'b0;
                    err_xfr_q  <= 1'b0;
                    err_nrdy_q <= wfn != FN_HOME && !unit_rdy;
                    err_wl_q   <= wfn == FN_WRITE && unit_rdy && locked;
                end
                if (state_q == ST_WAIT && tmr_zero) done_q <= 1'b1;
                if (state_q == ST_XWAIT && xfer_done) begin
                    done_q    <= 1'b1;
                    sect_q    <= nxt_sect;
                    trk_q     <= nxt_trk;
                    cyl_q     <= nxt_cyl;
                    err_ovf_q <= step_ovf;
                    err_xfr_q <= xfer_err;
                end
                if (reg_wr && !busy) begin
                    if (reg_addr == RA_DA) begin
                        sect_q <= reg_wdata[SECT_W-1:0];
                        trk_q  <= reg_wdata[DA_TRK +: TRK_W];
                    end
                    if (reg_addr == RA_CA)   cyl_q  <= reg_wdata[CYL_W-1:0];
                    if (reg_addr == RA_LOCK) lock_q <= reg_wdata[CYL_W-1:0];
                end
            end
        end
    end

    // outputs
    always_comb begin
        xfer_start = state_q == ST_XSTART;
        xfer_write = func_q == FN_WRITE;
        xfer_unit  = unit_q;
        irq        = done_q && ie_q;
        reg_rdata  = '0;
        unique case (reg_addr)
            RA_CS: begin
                reg_rdata[CS_FN +: 3]        = func_q;
                reg_rdata[CS_UNIT +: UNIT_W] = unit_q;
                reg_rdata[CS_DONE]           = done_q;
                reg_rdata[CS_IE]             = ie_q;
                reg_rdata[CS_WL]             = err_wl_q;
                reg_rdata[CS_NRDY]           = err_nrdy_q;
                reg_rdata[CS_OVF]            = err_ovf_q;
                reg_rdata[CS_XFR]            = err_xfr_q;
                reg_rdata[CS_ERR]            = err_wl_q | err_nrdy_q | err_ovf_q | err_xfr_q;
            end
            RA_DA: begin
                reg_rdata[SECT_W-1:0]       = sect_q;
                reg_rdata[DA_TRK +: TRK_W]  = trk_q;
            end
            RA_CA:   reg_rdata[CYL_W-1:0] = cyl_q;
            RA_DS:   reg_rdata[3:0] = {drv_st[unit_q].wlv, drv_st[unit_q].seek_inc,
                                       drv_st[unit_q].positioning, drv_rdy[unit_q]};
            RA_LOCK: reg_rdata[CYL_W-1:0] = lock_q;
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dsk_cmd_seq_chk.sv
module dsk_cmd_seq_chk
    import dsk_pkg::*;
#(
    parameter int NUM_DRV = 8,
    parameter int UNIT_W  = 3,
    parameter int DA_W    = 17
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr,
    input logic [2:0]         reg_addr,
    input logic [REG_W-1:0]   reg_wdata,
    input logic               irq,
    input logic               xfer_start,
    input logic               xfer_done,
    input logic [NUM_DRV-1:0] seek_fail,
    input logic               done,
    input logic               ie,
    input logic               busy,
    input logic               in_xwait,
    input logic [DA_W-1:0]    da,
    input logic [NUM_DRV-1:0] drv_rdy,
    input logic [NUM_DRV-1:0] drv_pos
);

    logic go_w, rst_go, idle_go;
    assign go_w    = reg_wr && reg_addr == RA_CS && reg_wdata[CS_GO];
    assign rst_go  = go_w && reg_wdata[CS_FN +: 3] == FN_RESET;
    assign idle_go = go_w && !busy;

    // R3: reset function completes next cycle with the written enable
    a_r3_reset_done: assert property (@(posedge clk) disable iff (!rst_n)
        rst_go |=> done && !busy && ie == $past(reg_wdata[CS_IE]));

    // R2: DONE rising under enable raises the request
    a_r2_irq_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done) && ie) |-> irq);

    // R4: seek/home never complete in the issuing cycle
    a_r4_no_instant_done: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_go && (reg_wdata[CS_FN +: 3] == FN_SEEK || reg_wdata[CS_FN +: 3] == FN_HOME))
        |=> !done);

    // R5: transfer start never coincides with completion
    a_r5_start_not_done: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_start && !rst_go) |=> !done);

    // R6: a finished transfer always moves the address
    a_r6_addr_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (in_xwait && xfer_done && !rst_go) |=> (done && da != $past(da)));

    for (genvar u = 0; u < NUM_DRV; u++) begin : g_u
        logic home_u;
        assign home_u = idle_go && reg_wdata[CS_FN +: 3] == FN_HOME &&
                        reg_wdata[CS_UNIT +: UNIT_W] == UNIT_W'(u);

        // R8: home readies the unit whatever its condition
        a_r8_home_readies: assert property (@(posedge clk) disable iff (!rst_n)
            home_u |=> drv_rdy[u]);

        // R9: failed seek leaves the unit not ready
        a_r9_fail_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
            (seek_fail[u] && drv_pos[u] && !home_u) |=> !drv_rdy[u]);
    end

endmodule

bind dsk_cmd_seq dsk_cmd_seq_chk #(
    .NUM_DRV (NUM_DRV),
    .UNIT_W  (UNIT_W),
    .DA_W    (SECT_W + TRK_W + CYL_W)
) i_dsk_cmd_seq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .irq        (irq),
    .xfer_start (xfer_start),
    .xfer_done  (xfer_done),
    .seek_fail  (seek_fail),
    .done       (done_q),
    .ie         (ie_q),
    .busy       (busy),
    .in_xwait   (state_q == dsk_pkg::ST_XWAIT),
    .da         ({cyl_q, trk_q, sect_q}),
    .drv_rdy    (drv_rdy),
    .drv_pos    ({g_drv[7].i_unit.st_q.positioning, g_drv[6].i_unit.st_q.positioning,
                  g_drv[5].i_unit.st_q.positioning, g_drv[4].i_unit.st_q.positioning,
                  g_drv[3].i_unit.st_q.positioning, g_drv[2].i_unit.st_q.positioning,
                  g_drv[1].i_unit.st_q.positioning, g_drv[0].i_unit.st_q.positioning})
);

// File: tb/test_dsk_cmd_seq.sv
module test_dsk_cmd_seq;

    localparam int NSEC = 12;
    localparam int NTRK = 20;
    localparam int NCYL = 203;
    localparam int DLY  = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq, xfer_start, xfer_write;
    logic [2:0]  xfer_unit;
    logic        xfer_done = 1'b0;
    logic        xfer_err = 1'b0;
    logic [7:0]  seek_cmpl = '0;
    logic [7:0]  seek_fail = '0;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    dsk_cmd_seq i_dsk_cmd_seq (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .xfer_start(xfer_start), .xfer_write(xfer_write), .xfer_unit(xfer_unit),
        .xfer_done(xfer_done), .xfer_err(xfer_err),
        .seek_cmpl(seek_cmpl), .seek_fail(seek_fail)
    );

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [15:0] exp, input string req);
        reg_addr = a;
        #1;
        chk(reg_rdata === exp, req, reg_rdata, exp);
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [15:0] cs_word(input bit go, input int fn, input int u, input bit ie);
        return 16'(go) | 16'(fn << 1) | 16'(u << 4) | 16'(int'(ie) << 8);
    endfunction

    function automatic logic [15:0] exp_cs(input int fn, input int u, input bit ie, input bit done,
                                           input bit wl, input bit nrdy, input bit ovf, input bit xfr);
        logic [15:0] v;
        v = cs_word(1'b0, fn, u, ie);
        v[7] = done; v[11] = wl; v[12] = nrdy; v[13] = ovf; v[14] = xfr;
        v[15] = wl | nrdy | ovf | xfr;
        return v;
    endfunction

    // expected address after one sector: {ovf, sector, track, cylinder}
    task automatic exp_step(input int s, input int t, input int c,
                            output int s2, output int t2, output int c2, output bit ovf);
        s2 = s + 1; t2 = t; c2 = c; ovf = 1'b0;
        if (s2 >= NSEC) begin
            s2 = 0; t2 = t + 1;
            if (t2 >= NTRK) begin
                t2 = 0; c2 = c + 1;
                if (c2 >= NCYL) begin c2 = 0; ovf = 1'b1; end
            end
        end
    endtask

    // issue read/write, check start strobe and late completion
    task automatic xfer_run(input int fn, input int u, input bit err, input int lat);
        wr(3'd0, cs_word(1'b1, fn, u, 1'b0));
        chk(xfer_start === 1'b1, "R5 xfer_start after GO", xfer_start, 1);
        chk(xfer_write === (fn == 1), "R5 xfer_write", xfer_write, fn == 1);
        cycles(lat);
        chk(xfer_start === 1'b0, "R5 start is one cycle", xfer_start, 0);
        rd_chk(3'd0, exp_cs(fn, u, 1'b0, 1'b0, 0, 0, 0, 0), "R5 DONE clear before engine done");
        xfer_err = err; xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0; xfer_err = 1'b0;
    endtask

    task automatic addr_case(input int s, input int t, input int c, input int fn, input int u,
                             input bit err, input int lat, input string req);
        int s2, t2, c2;
        bit ovf;
        wr(3'd1, 16'((t << 8) | s));
        wr(3'd2, 16'(c));
        exp_step(s, t, c, s2, t2, c2, ovf);
        xfer_run(fn, u, err, lat);
        rd_chk(3'd1, 16'((t2 << 8) | s2), {req, " sector/track"});
        rd_chk(3'd2, 16'(c2), {req, " cylinder"});
        rd_chk(3'd0, exp_cs(fn, u, 1'b0, 1'b1, 0, 0, ovf, err), {req, " status word"});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
        report();
    end

    initial begin
        void'($urandom(32'd2718));
        cycles(3);
        rst_n = 1'b1;
        cycles(1);

        // R1 reset state
        rd_chk(3'd0, 16'h0080, "R1 status word");
        rd_chk(3'd1, 16'h0000, "R1 disk address");
        rd_chk(3'd2, 16'h0000, "R1 cylinder");
        rd_chk(3'd3, 16'h0001, "R1 unit status");
        rd_chk(3'd4, 16'h0000, "R1 lock boundary");
        chk(irq === 1'b0, "R1 irq low", irq, 0);

        // R2 enable while DONE set
        wr(3'd0, 16'h0100);
        chk(irq === 1'b1, "R2 irq with enable and DONE", irq, 1);
        wr(3'd0, 16'h0000);
        chk(irq === 1'b0, "R2 irq drops with enable", irq, 0);

        // R4 / R9 seek timing and positioning
        wr(3'd2, 16'd50);
        wr(3'd0, cs_word(1'b1, 3, 2, 1'b1));
        chk(irq === 1'b0, "R4 no irq at seek issue", irq, 0);
        rd_chk(3'd3, 16'h0002, "R9 positioning during seek");
        cycles(DLY - 1);
        rd_chk(3'd0, exp_cs(3, 2, 1'b1, 1'b0, 0, 0, 0, 0), "R4 DONE clear one cycle early");
        cycles(1);
        rd_chk(3'd0, exp_cs(3, 2, 1'b1, 1'b1, 0, 0, 0, 0), "R4 DONE at delay");
        chk(irq === 1'b1, "R2 irq at seek completion", irq, 1);
        seek_cmpl[2] = 1'b1; cycles(1); seek_cmpl[2] = 1'b0;
        rd_chk(3'd3, 16'h0001, "R9 ready after seek complete");

        // R9 / R10 / R8 failed seek on unit 3
        wr(3'd0, cs_word(1'b1, 3, 3, 1'b0));
        cycles(DLY);
        seek_fail[3] = 1'b1; cycles(1); seek_fail[3] = 1'b0;
        rd_chk(3'd3, 16'h0004, "R9 seek incomplete");
        wr(3'd0, cs_word(1'b1, 2, 3, 1'b0));
        chk(xfer_start === 1'b0, "R10 no transfer to not-ready unit", xfer_start, 0);
        cycles(DLY);
        rd_chk(3'd0, exp_cs(2, 3, 1'b0, 1'b1, 0, 1, 0, 0), "R10 not-ready completion");
        wr(3'd0, cs_word(1'b1, 0, 3, 1'b0));
        rd_chk(3'd0, exp_cs(0, 3, 1'b0, 1'b1, 0, 0, 0, 0), "R3 reset clears errors");
        rd_chk(3'd3, 16'h0004, "R9 seek incomplete survives reset");
        wr(3'd0, cs_word(1'b1, 4, 3, 1'b0));
        rd_chk(3'd3, 16'h0001, "R8 home on not-ready unit");
        rd_chk(3'd0, exp_cs(4, 3, 1'b0, 1'b0, 0, 0, 0, 0), "R4 home DONE delayed");
        cycles(DLY);
        rd_chk(3'd0, exp_cs(4, 3, 1'b0, 1'b1, 0, 0, 0, 0), "R4 home DONE at delay");

        // R3 reset while a transfer is outstanding
        wr(3'd1, 16'h0205);
        wr(3'd0, cs_word(1'b1, 2, 0, 1'b0));
        chk(xfer_start === 1'b1, "R5 start before abort", xfer_start, 1);
        cycles(2);
        wr(3'd0, cs_word(1'b1, 0, 0, 1'b1));
        rd_chk(3'd0, exp_cs(0, 0, 1'b1, 1'b1, 0, 0, 0, 0), "R3 reset accepted while busy");
        chk(irq === 1'b1, "R3 reset interrupt with enable", irq, 1);
        xfer_done = 1'b1; cycles(1); xfer_done = 1'b0;
        rd_chk(3'd1, 16'h0205, "R3 late engine done ignored");

        // R11 / R12 write lock
        wr(3'd4, 16'd10);
        wr(3'd2, 16'd5);
        wr(3'd0, cs_word(1'b1, 1, 1, 1'b0));
        chk(xfer_start === 1'b0, "R11 locked write not started", xfer_start, 0);
        rd_chk(3'd3, 16'h0009, "R11 unit write-lock flag");
        cycles(DLY);
        rd_chk(3'd0, exp_cs(1, 1, 1'b0, 1'b1, 1, 0, 0, 0), "R11 lock completion");
        rd_chk(3'd1, 16'h0205, "R11 address unchanged");
        wr(3'd0, cs_word(1'b0, 0, 4, 1'b0));
        rd_chk(3'd3, 16'h0001, "R12 other unit unaffected");
        addr_case(5, 2, 5, 2, 1, 1'b0, 2, "R11 read of locked cylinder");
        wr(3'd0, cs_word(1'b1, 0, 1, 1'b0));
        rd_chk(3'd3, 16'h0001, "R3 reset clears write-lock flag");
        wr(3'd4, 16'd0);

        // R13 ignored GO writes
        wr(3'd0, cs_word(1'b1, 6, 0, 1'b0));
        chk(xfer_start === 1'b0, "R13 code 6 starts nothing", xfer_start, 0);
        rd_chk(3'd0, exp_cs(6, 0, 1'b0, 1'b1, 0, 0, 0, 0), "R13 DONE kept");
        wr(3'd1, 16'h0000);
        wr(3'd0, cs_word(1'b1, 2, 0, 1'b0));
        wr(3'd0, cs_word(1'b1, 3, 6, 1'b0));
        rd_chk(3'd0, exp_cs(2, 0, 1'b0, 1'b0, 0, 0, 0, 0), "R13 busy GO ignored");
        xfer_done = 1'b1; cycles(1); xfer_done = 1'b0;
        rd_chk(3'd1, 16'h0001, "R6 sector after busy-ignored case");

        // R6 / R7 directed address corners
        addr_case(3, 0, 7, 2, 0, 1'b1, 1, "R6 advance despite fault");
        addr_case(NSEC - 1, 4, 9, 1, 2, 1'b0, 3, "R6 track carry");
        addr_case(NSEC - 1, NTRK - 1, 9, 2, 4, 1'b0, 1, "R6 cylinder carry");
        addr_case(NSEC - 1, NTRK - 1, NCYL - 1, 2, 5, 1'b0, 2, "R7 pack overflow");

        // random transfers
        for (int i = 0; i < 40; i++) begin
            int s, t, c;
            s = ($urandom % 4 == 0) ? NSEC - 1 : int'($urandom % NSEC);
            t = ($urandom % 4 == 0) ? NTRK - 1 : int'($urandom % NTRK);
            c = ($urandom % 4 == 0) ? NCYL - 1 : int'($urandom % NCYL);
            addr_case(s, t, c, 1 + int'($urandom % 2), int'($urandom % 8),
                      1'($urandom % 2), 1 + int'($urandom % 6), "R6 random transfer");
        end

        report();
    end

endmodule